// File: doc/BRIEF.md
# Filtered Address-Edge Scanline Counter

This block sits inside a cartridge mapper and counts video scanlines. It watches a single address line of the graphics chip: the bit that selects the upper half of pattern memory. When background tiles are fetched, that line stays low for most of a scanline. When sprite patterns are fetched from the upper half, the line goes high for each sprite. Between two sprite fetches it drops low again, but only briefly, because of dummy nametable reads. A plain edge counter would count several times per line.

The block first brings the address line into the CPU clock domain. It then measures how long the line has been low, in CPU clock cycles. A rising edge is passed on only if that low run reached a threshold, `LOW_CYCLES`, which defaults to 5 and is meant to be set from 4 to 6. One CPU cycle is three pixels, and each fetch lasts two pixels, so the short gaps between sprite fetches fall well below the threshold.

Each qualified edge clocks an 8-bit down-counter. The counter reloads from a latch when it is zero or when a reload has been requested. The block raises an interrupt when the counter reaches zero with the interrupt enabled. Firmware sets the latch, requests reloads and enables, disables or acknowledges the interrupt through a small write port.

Top module: `scanline_irq_counter`

## Requirements
- R1: The address line passes through two synchronizing flip-flops. A qualified rise driven on `a12_in` first shows its effect on `irq_o` after the third rising clock edge that samples it.
- R2: A low-run tally counts clock cycles in which the synchronized line is low. It saturates at `LOW_CYCLES` and clears in any cycle the synchronized line is high.
- R3: A synchronized rising edge clocks the counter only if the low run just before it lasted at least `LOW_CYCLES` cycles. A rise after a shorter low run has no effect.
- R4: On a qualified edge, the counter loads the latch value if the counter is zero or a reload is pending, and the pending reload is cleared. Otherwise the counter decrements by one.
- R5: If the counter is zero right after a qualified edge and the interrupt is enabled, `irq_o` goes high.
- R6: `irq_o` is low after reset. Once high, it stays high until the interrupt is disabled.
- R7: Writes are decoded from `reg_sel` when `reg_we` is high:
  - 0 stores `reg_wdata` in the latch.
  - 1 requests a reload.
  - 2 disables the interrupt and clears `irq_o`.
  - 3 enables the interrupt.

  A disable wins over an interrupt set in the same cycle. A reload request wins over the clearing done by an edge in the same cycle. While the interrupt is disabled, edges never raise `irq_o`.
- R8: A scanline produces exactly one count when every low gap between its upper-half sprite fetches is shorter than `LOW_CYCLES`. A gap at or above the threshold produces an additional count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| a12_in | input | 1 | Pattern-half select line of the graphics address bus, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Write target: 0 latch, 1 reload request, 2 interrupt off/ack, 3 interrupt on |
| reg_wdata | input | CNT_W | Latch value for writes with select 0 |
| irq_o | output | 1 | Registered interrupt request, active high |

## Verification
The bench plays whole scanlines with sprite upper-half fetches placed in different slots. It counts interrupts per line, so a missing filter shows up as extra counts and an over-strict filter shows up as lost counts. Isolated low pulses of exactly `LOW_CYCLES-1` and `LOW_CYCLES` cycles test the boundary; an off-by-one in the tally either accepts the short pulse or rejects the legal one. The bench also runs a latch-three countdown to catch a counter that fires one line early or never reloads from zero. A latency probe catches a missing or extra synchronizer stage.

// File: rtl/scl_pkg.sv
package scl_pkg;
  typedef enum logic [1:0] {
    SEL_LATCH   = 2'd0,
    SEL_RELOAD  = 2'd1,
    SEL_IRQ_OFF = 2'd2,
    SEL_IRQ_ON  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/scl_a12_sync.sv
module scl_a12_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/scl_low_filter.sv
module scl_low_filter #(
  parameter int LOW_CYCLES = 5,
  parameter int LW         = $clog2(LOW_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a12_s,
  output logic          fire,
  output logic [LW-1:0] low_cnt
);
  localparam logic [LW-1:0] LIMIT = LW'(LOW_CYCLES);

  // Tally of low cycles; saturates so the width stays small.
  always_ff @(posedge clk) begin
    if (rst)                  low_cnt <= '0;
    else if (a12_s)           low_cnt <= '0;
    else if (low_cnt < LIMIT) low_cnt <= low_cnt + 1'b1;
  end

  // A nonzero tally implies the previous sample was low, so a high
  // sample with a full tally is a qualified rising edge.
  assign fire = a12_s && (low_cnt >= LIMIT);
endmodule

// File: rtl/scl_line_counter.sv
module scl_line_counter
  import scl_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic             reg_we,
  input  logic [1:0]       reg_sel,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic             pend_q,
  output logic             irq_q
);
  logic [CNT_W-1:0] latch_q;
  logic [CNT_W-1:0] cnt_d;
  logic             en_q;
  logic             wr_latch, wr_reload, wr_off, wr_on;

  assign wr_latch  = reg_we && (reg_sel == SEL_LATCH);
  assign wr_reload = reg_we && (reg_sel == SEL_RELOAD);
  assign wr_off    = reg_we && (reg_sel == SEL_IRQ_OFF);
  assign wr_on     = reg_we && (reg_sel == SEL_IRQ_ON);

  always_comb begin
    if ((cnt_q == '0) || pend_q) cnt_d = latch_q;
    else                         cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      en_q    <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_latch) latch_q <= reg_wdata;
      if (fire) begin
        cnt_q  <= cnt_d;
        pend_q <= 1'b0;
      end
      if (wr_reload) pend_q <= 1'b1;
      if (wr_off)     en_q <= 1'b0;
      else if (wr_on) en_q <= 1'b1;
      if (wr_off)
        irq_q <= 1'b0;
      else if (fire && (cnt_d == '0) && en_q)
        irq_q <= 1'b1;
    end
  end
endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter #(
  parameter int LOW_CYCLES  = 5,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a12_in,
  input  logic             reg_we,
  input  logic [1:0]       reg_sel,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic             irq_o
);
  localparam int LW = $clog2(LOW_CYCLES + 1);

  logic             a12_s;
  logic             fire;
  logic [LW-1:0]    low_cnt;
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;

  scl_a12_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d(a12_in), .q(a12_s)
  );

  scl_low_filter #(.LOW_CYCLES(LOW_CYCLES), .LW(LW)) filt_i (
    .clk(clk), .rst(rst), .a12_s(a12_s), .fire(fire), .low_cnt(low_cnt)
  );

  scl_line_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .fire(fire),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .cnt_q(cnt_q), .pend_q(pend_q), .irq_q(irq_o)
  );
endmodule

// File: rtl/scanline_irq_counter_chk.sv
module scanline_irq_counter_chk #(
  parameter int LOW_CYCLES = 5,
  parameter int CNT_W      = 8,
  parameter int LW         = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             a12_s,
  input logic             fire,
  input logic [LW-1:0]    low_cnt,
  input logic [CNT_W-1:0] cnt_q,
  input logic             pend_q,
  input logic             reg_we,
  input logic [1:0]       reg_sel,
  input logic             irq_o
);
  AST_LOW_SAT: assert property (@(posedge clk) disable iff (rst)
    low_cnt <= LW'(LOW_CYCLES)); // R2

  AST_FIRE_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
    fire |-> $past(!a12_s)); // R3

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire); // R3

  AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
    (fire && (cnt_q != '0) && !pend_q) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4

  AST_RELOAD_DONE: assert property (@(posedge clk) disable iff (rst)
    (fire && !(reg_we && reg_sel == 2'd1)) |=> !pend_q); // R4

  AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> (cnt_q == '0)); // R5

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !(reg_we && reg_sel == 2'd2)) |=> irq_o); // R6

  AST_IRQ_OFF: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_sel == 2'd2) |=> !irq_o); // R7
endmodule

bind scanline_irq_counter scanline_irq_counter_chk #(
  .LOW_CYCLES(LOW_CYCLES), .CNT_W(CNT_W), .LW(LW)
) chk_i (
  .clk(clk), .rst(rst), .a12_s(a12_s), .fire(fire), .low_cnt(low_cnt),
  .cnt_q(cnt_q), .pend_q(pend_q), .reg_we(reg_we), .reg_sel(reg_sel),
  .irq_o(irq_o)
);

// File: tb/scanline_irq_counter_tb_top.sv
`timescale 1ns/1ps
module scanline_irq_counter_tb_top;
  localparam int T     = 5;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             a12_in = 1'b0;
  logic             reg_we = 1'b0;
  logic [1:0]       reg_sel = 2'd0;
  logic [CNT_W-1:0] reg_wdata = '0;
  logic             irq_o;

  int checks = 0;
  int errors = 0;
  int hits = 0;
  bit auto_ack = 0;
  int ack_phase = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  scanline_irq_counter #(.LOW_CYCLES(T), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .a12_in(a12_in), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .irq_o(irq_o)
  );

  // Behavioural reference model
  int m_q[$];
  int m_low, m_cnt, m_latch;
  bit m_pend, m_en, m_irq;
  always @(posedge clk) begin
    if (rst) begin
      m_q = {0, 0};
      m_low = 0; m_cnt = 0; m_latch = 0;
      m_pend = 0; m_en = 0; m_irq = 0;
    end else begin
      int  line_now;
      bit  edge_ok;
      int  nxt;
      bit  en_old;
      line_now = m_q[1];
      edge_ok = (line_now == 1) && (m_low >= T);
      en_old = m_en;
      nxt = (m_cnt == 0 || m_pend) ? m_latch : m_cnt - 1;
      if (reg_we && reg_sel == 2'd0) m_latch = reg_wdata;
      if (edge_ok) begin m_cnt = nxt; m_pend = 0; end
      if (reg_we && reg_sel == 2'd1) m_pend = 1;
      if (reg_we && reg_sel == 2'd2) m_en = 0;
      else if (reg_we && reg_sel == 2'd3) m_en = 1;
      if (reg_we && reg_sel == 2'd2) m_irq = 0;
      else if (edge_ok && nxt == 0 && en_old) m_irq = 1;
      if (line_now == 1) m_low = 0;
      else if (m_low < T) m_low = m_low + 1;
      void'(m_q.pop_back());
      m_q.push_front(int'(a12_in));
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) check("R5/R6 model", int'(irq_o), int'(m_irq));
  end

  // One cycle of stimulus, applied at a falling edge.
  task automatic step(bit a);
    a12_in = a;
    reg_we = 1'b0;
    if (ack_phase == 1) begin
      reg_we = 1'b1; reg_sel = 2'd3; ack_phase = 0;
    end else if (auto_ack && irq_o) begin
      reg_we = 1'b1; reg_sel = 2'd2; ack_phase = 1; hits++;
    end
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] sel, logic [CNT_W-1:0] data);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic play_line(logic [7:0] mask);
    for (int i = 0; i < 85; i++) step(1'b0);
    for (int s = 0; s < 8; s++) begin
      step(1'b0);
      step(mask[s]);
      step(mask[s]);
    end
    for (int i = 0; i < 6; i++) step(1'b0);
  endtask

  function automatic int expected_counts(logic [7:0] mask);
    int prev = -1;
    int n = 0;
    for (int s = 0; s < 8; s++) begin
      if (mask[s]) begin
        if (prev < 0) n++;
        else if (1 + 3 * (s - prev - 1) >= T) n++;
        prev = s;
      end
    end
    return n;
  endfunction

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] pats [8];
    int h0;
    pats = '{8'hFF, 8'h81, 8'h03, 8'h05, 8'h09, 8'h11, 8'h0F, 8'hAA};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R6 reset irq low", int'(irq_o), 0);

    // R1 latency: latch 0, interrupt enabled, one clean rise
    wr(2'd0, 8'd0);
    wr(2'd3, 8'd0);
    for (int i = 0; i < 20; i++) step(1'b0);
    step(1'b1);
    check("R1 after 1 edge", int'(irq_o), 0);
    step(1'b1);
    check("R1 after 2 edges", int'(irq_o), 0);
    step(1'b1);
    check("R1 after 3 edges", int'(irq_o), 1);
    wr(2'd2, 8'd0);
    check("R7 disable clears", int'(irq_o), 0);

    // R7 disabled: edges do not raise irq
    play_line(8'h81);
    check("R7 disabled stays low", int'(irq_o), 0);
    wr(2'd3, 8'd0);

    // R3/R2 boundary pulses
    auto_ack = 1;
    foreach (pats[k]) begin end
    for (int k = T - 1; k <= T; k++) begin
      for (int i = 0; i < 20; i++) step(1'b0);
      h0 = hits;
      for (int i = 0; i < 3; i++) step(1'b1);
      for (int i = 0; i < k; i++) step(1'b0);
      for (int i = 0; i < 3; i++) step(1'b1);
      for (int i = 0; i < 10; i++) step(1'b0);
      check(k >= T ? "R3 low run at threshold counts" : "R2 low run below threshold ignored",
            hits - h0, k >= T ? 2 : 1);
    end
    h0 = hits;
    for (int i = 0; i < 3; i++) step(1'b1);
    step(1'b0);
    for (int i = 0; i < 3; i++) step(1'b1);
    for (int i = 0; i < 10; i++) step(1'b0);
    check("R3 one-cycle glitch ignored", hits - h0, 1);

    // R8 scanlines with sprite fetch patterns
    for (int p = 0; p < 8; p++) begin
      h0 = hits;
      play_line(pats[p]);
      check($sformatf("R8 counts for mask %02h", pats[p]), hits - h0,
            expected_counts(pats[p]));
    end
    auto_ack = 0;
    step(1'b0); step(1'b0);

    // R4/R5 countdown from latch 3
    wr(2'd0, 8'd3);
    wr(2'd1, 8'd0);
    wr(2'd2, 8'd0);
    wr(2'd3, 8'd0);
    for (int l = 1; l <= 4; l++) begin
      play_line(8'h80);
      check($sformatf("R5 irq after line %0d", l), int'(irq_o), l == 4 ? 1 : 0);
    end
    step(1'b0);
    check("R6 irq held", int'(irq_o), 1);
    wr(2'd2, 8'd0);
    wr(2'd3, 8'd0);
    play_line(8'h80);
    check("R4 reload from zero, no irq", int'(irq_o), 0);
    for (int l = 0; l < 3; l++) play_line(8'h80);
    check("R4 decrement to zero again", int'(irq_o), 1);

    repeat (4) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule